// File: doc/BRIEF.md
# Graded Sleep Clock Controller

This controller owns the clock enables around a processor core for three sleep depths. Software writes a two-bit depth code. From then on the controller gates the core clock alone (light sleep), or the whole on-chip clock tree at the PLL output (medium sleep), or the tree and also the path from the external reference into the PLL (deep sleep). No register content is touched in any depth, so software context survives every sleep.

A wake request brings the clocks back in a fixed order. Light and medium sleep return in two reference edges: the tree first, then the core. Deep sleep first reconnects the reference to the PLL. It then holds the tree off for a lock window set by a count input, which stands in for the time the PLL needs to relock. A clocks-valid output goes high only once every enable for the running state is back. Depth writes that arrive while a wake is under way are dropped.

Top module: `pwrdn_clk_ctrl`

## Requirements
- R1: During and straight after reset the controller is running: core enable, tree enable, reference-connect enable and clocks-valid are all 1.
- R2: A write of code 2'b01 while running gives, from the next edge on, core enable 0, tree enable 1, reference-connect 1 and clocks-valid 0.
- R3: A write of code 2'b10 while running gives core enable 0, tree enable 0, reference-connect 1 and clocks-valid 0.
- R4: A write of code 2'b11 while running gives core enable 0, tree enable 0, reference-connect 0 and clocks-valid 0.
- R5: A write of code 2'b00 while running leaves all four outputs at 1.
- R6: A wake request seen at an edge during light or medium sleep turns the tree enable on after that edge. Core enable and clocks-valid follow at the next edge.
- R7: A wake request seen at an edge during deep sleep turns reference-connect on after that edge. The tree enable comes on L+1 edges later, and core enable and clocks-valid come on L+2 edges later, where L is the lock count.
- R8: The lock count is captured at the edge that takes the wake request. Later changes to the count input do not alter that wake.
- R9: Depth writes are ignored while asleep and while a wake sequence is in progress.
- R10: A wake request while running has no effect.
- R11: Clocks-valid is 1 only when all three enables are 1. The core enable is never on without the tree enable, and the tree enable is never on without reference-connect.
- R12: A lock count of 0 gives the shortest deep wake: tree enable after the second edge, core enable after the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr | input | 1 | Strobe that writes the sleep depth code |
| mode_req | input | 2 | Depth code: 00 run, 01 light, 10 medium, 11 deep |
| wake_req | input | 1 | Request to leave sleep |
| lock_cnt_cfg | input | LOCK_W | Relock wait length in reference cycles |
| cpu_clk_en | output | 1 | Enable for the core clock |
| tree_clk_en | output | 1 | Enable for the clock tree at the PLL output |
| ref_connect_en | output | 1 | Connects the external reference to the PLL |
| clocks_valid | output | 1 | All clocks restored for the running state |

## Verification
All outputs are decoded from one state register, so every response is due one edge after the edge that takes the stimulus. The wake responses are due at edge 1 and edge 2 for light and medium sleep, and at edges 1, L+2 and L+3 for deep sleep, counting the edge that takes the request as edge 1. The bench drives inputs on falling edges and checks all four outputs on the falling edge after each rising edge. It walks the edge index through each wake and computes the expected vector from the depth and the lock count. It sweeps every depth against lock counts 0 to 5, and it changes the count input and issues depth writes in the middle of each wake.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_LITE = 2'b01;
  localparam logic [1:0] MODE_MED  = 2'b10;
  localparam logic [1:0] MODE_DEEP = 2'b11;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_LITE   = 3'd1,
    ST_MED    = 3'd2,
    ST_DEEP   = 3'd3,
    ST_RELOCK = 3'd4,
    ST_RESUME = 3'd5
  } pd_state_t;

  typedef struct packed {
    logic cpu;
    logic tree;
    logic refc;
    logic valid;
  } pd_en_t;
endpackage

// File: rtl/pd_lock_timer.sv
module pd_lock_timer #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LOCK_W-1:0] load_val,
  input  logic              run,
  output logic              done
);
  logic [LOCK_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = load | (run & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R8: captured count is the value present at the load edge
  a_r8_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

  // R7: the wait shortens by exactly one per cycle
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_req,
  input  logic       wake_req,
  input  logic       lock_done,
  output pd_state_t  state,
  output logic       lock_load,
  output logic       lock_run
);
  pd_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN: begin
        if (mode_wr) begin
          unique case (mode_req)
            MODE_LITE: st_d = ST_LITE;
            MODE_MED:  st_d = ST_MED;
            MODE_DEEP: st_d = ST_DEEP;
            default:   st_d = ST_RUN;
          endcase
        end
      end
      ST_LITE, ST_MED: if (wake_req) st_d = ST_RESUME;
      ST_DEEP:         if (wake_req) st_d = ST_RELOCK;
      ST_RELOCK:       if (lock_done) st_d = ST_RESUME;
      ST_RESUME:       st_d = ST_RUN;
      default:         st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  assign state     = st_q;
  assign lock_load = (st_q == ST_DEEP) & wake_req;
  assign lock_run  = (st_q == ST_RELOCK);

  // R6: light or medium wake reaches the resume step at once
  a_r6_short_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_LITE || st_q == ST_MED) && wake_req) |=> (st_q == ST_RESUME));

  // R7: deep sleep leaves only through the relock wait
  a_r7_deep_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEEP) |=> (st_q == ST_DEEP || st_q == ST_RELOCK));

  // R9: no depth write enters a sleep state during a wake
  a_r9_wake_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RELOCK || st_q == ST_RESUME) |=>
      (st_q == ST_RELOCK || st_q == ST_RESUME || st_q == ST_RUN));

  // R10: running state is left only by a depth write
  a_r10_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !mode_wr) |=> (st_q == ST_RUN));
endmodule

// File: rtl/pd_enable_decode.sv
module pd_enable_decode
  import pd_pkg::*;
(
  input  pd_state_t state,
  output pd_en_t    en
);
  always_comb begin
    en = '{cpu: 1'b0, tree: 1'b0, refc: 1'b0, valid: 1'b0};
    unique case (state)
      ST_RUN:    en = '{cpu: 1'b1, tree: 1'b1, refc: 1'b1, valid: 1'b1};
      ST_LITE:   en = '{cpu: 1'b0, tree: 1'b1, refc: 1'b1, valid: 1'b0};
      ST_MED:    en = '{cpu: 1'b0, tree: 1'b0, refc: 1'b1, valid: 1'b0};
      ST_DEEP:   en = '{cpu: 1'b0, tree: 1'b0, refc: 1'b0, valid: 1'b0};
      ST_RELOCK: en = '{cpu: 1'b0, tree: 1'b0, refc: 1'b1, valid: 1'b0};
      ST_RESUME: en = '{cpu: 1'b0, tree: 1'b1, refc: 1'b1, valid: 1'b0};
      default:   en = '{cpu: 1'b1, tree: 1'b1, refc: 1'b1, valid: 1'b1};
    endcase
  end
endmodule

// File: rtl/pwrdn_clk_ctrl.sv
module pwrdn_clk_ctrl
  import pd_pkg::*;
#(
  parameter int LOCK_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_req,
  input  logic              wake_req,
  input  logic [LOCK_W-1:0] lock_cnt_cfg,
  output logic              cpu_clk_en,
  output logic              tree_clk_en,
  output logic              ref_connect_en,
  output logic              clocks_valid
);
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_int_n;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STG-1];

  pd_state_t st;
  logic      lock_load, lock_run, lock_done;
  pd_en_t    en;

  pd_seq_fsm u_fsm (
    .clk       (clk_ref),
    .rst_n     (rst_int_n),
    .mode_wr   (mode_wr),
    .mode_req  (mode_req),
    .wake_req  (wake_req),
    .lock_done (lock_done),
    .state     (st),
    .lock_load (lock_load),
    .lock_run  (lock_run)
  );

  pd_lock_timer #(.LOCK_W(LOCK_W)) u_lock (
    .clk      (clk_ref),
    .rst_n    (rst_int_n),
    .load     (lock_load),
    .load_val (lock_cnt_cfg),
    .run      (lock_run),
    .done     (lock_done)
  );

  pd_enable_decode u_dec (
    .state (st),
    .en    (en)
  );

  assign cpu_clk_en     = en.cpu;
  assign tree_clk_en    = en.tree;
  assign ref_connect_en = en.refc;
  assign clocks_valid   = en.valid;

  // R11: enables nest and valid needs all of them
  a_r11_valid_full: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    clocks_valid |-> (cpu_clk_en && tree_clk_en && ref_connect_en));
  a_r11_cpu_needs_tree: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    cpu_clk_en |-> tree_clk_en);
  a_r11_tree_needs_ref: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    tree_clk_en |-> ref_connect_en);

  // R7: reference reconnects right after a deep wake is taken
  a_r7_ref_first: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    (!ref_connect_en && wake_req) |=> (ref_connect_en && !tree_clk_en));
endmodule

// File: tb/sim_pwrdn_clk_ctrl.sv
module sim_pwrdn_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK_W     = 8;

  logic              clk_ref = 1'b0;
  logic              rst_n;
  logic              mode_wr;
  logic [1:0]        mode_req;
  logic              wake_req;
  logic [LOCK_W-1:0] lock_cnt_cfg;
  logic              cpu_clk_en, tree_clk_en, ref_connect_en, clocks_valid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  pwrdn_clk_ctrl #(.LOCK_W(LOCK_W)) u0 (
    .clk_ref, .rst_n, .mode_wr, .mode_req, .wake_req, .lock_cnt_cfg,
    .cpu_clk_en, .tree_clk_en, .ref_connect_en, .clocks_valid
  );

  task automatic chk(input string tag, input logic [3:0] expv);
    logic [3:0] got;
    got = {cpu_clk_en, tree_clk_en, ref_connect_en, clocks_valid};
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, expv, $time);
    end
  endtask

  function automatic logic [3:0] sleep_vec(input int m);
    case (m)
      1:       return 4'b0110;
      2:       return 4'b0010;
      default: return 4'b0000;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_req = 2'b00; wake_req = 1'b0;
    lock_cnt_cfg = '0;
    repeat (3) @(negedge clk_ref);
    chk("R1 in reset", 4'b1111);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_ref);
    chk("R1 after reset", 4'b1111);

    // R5: code 00 keeps running
    mode_wr = 1'b1; mode_req = 2'b00;
    @(negedge clk_ref); mode_wr = 1'b0;
    chk("R5 write 00", 4'b1111);

    // R10: wake while running
    wake_req = 1'b1;
    @(negedge clk_ref); wake_req = 1'b0;
    chk("R10 wake in run", 4'b1111);
    @(negedge clk_ref);
    chk("R10 wake in run later", 4'b1111);

    for (int m = 1; m <= 3; m++) begin
      for (int cfg = 0; cfg <= 5; cfg++) begin
        int n;
        n = (m == 3) ? cfg + 3 : 2;
        lock_cnt_cfg = LOCK_W'(cfg);
        mode_wr = 1'b1; mode_req = 2'(m);
        @(negedge clk_ref); mode_wr = 1'b0;
        chk(m == 1 ? "R2 light sleep" : (m == 2 ? "R3 medium sleep" : "R4 deep sleep"),
            sleep_vec(m));
        // R9: write while asleep
        mode_wr = 1'b1; mode_req = (m == 1) ? 2'b11 : 2'b01;
        @(negedge clk_ref); mode_wr = 1'b0;
        chk("R9 write while asleep", sleep_vec(m));
        @(negedge clk_ref);
        chk("R9 asleep hold", sleep_vec(m));
        // wake
        wake_req = 1'b1;
        for (int k = 1; k <= n + 1; k++) begin
          logic [3:0] e;
          @(negedge clk_ref);
          wake_req = 1'b0;
          if (k == 1) lock_cnt_cfg = LOCK_W'(cfg + 7); // R8
          mode_wr  = (k + 1 >= 2) && (k + 1 <= n);
          mode_req = 2'(m);
          if (k >= n)          e = 4'b1111;
          else if (k == n - 1) e = 4'b0110;
          else                 e = 4'b0010;
          if (m == 3 && cfg == 0) chk("R12 zero lock wake", e);
          else if (m == 3)        chk("R7 R8 deep wake step", e);
          else                    chk("R6 short wake step", e);
        end
        mode_wr = 1'b0;
        @(negedge clk_ref);
        chk("R9 write during wake ignored", 4'b1111);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule